// File: doc/BRIEF.md
# ATA-to-SATA Port Routing Crossbar

This block connects two parallel ATA host controllers to two serial adapters and to one external parallel-ATA pad group. Each controller has a master device port and a slave device port. Each port carries an abstract request bundle out of the controller and takes a response bundle back. A 3-bit routing code in a memory-mapped control register picks one of four fixed topologies. In each topology, some ports reach an adapter, some reach the pads, and some are left idle. A bridge-enable bit gates the adapter links. A per-controller "bridged" output tells the controller driver whether that controller reaches a serial adapter.

The pad group has two lanes. Lane 0 carries a controller's master port and lane 1 carries a controller's slave port. In one topology a single slave port is routed to an adapter and to pad lane 1 at once. The request fans out to both destinations. The response is taken from the adapter while the bridge is enabled, and from the pad lane otherwise. Writing a reserved routing code idles every route and sets a sticky error flag. The flag stays set until reset.

Port numbering used throughout: port 0 is controller 0 master, port 1 is controller 0 slave, port 2 is controller 1 master, port 3 is controller 1 slave. Unrouted request and response outputs are driven to all zeros.

Top module: `ata_sata_xbar`

## Requirements
- R1: After synchronous reset, the routing code is 0, bridge enable is 0, the sticky flag is 0, and a read of the control register at offset 0x30 returns 0.
- R2: The control register sits at offset 0x30, and reads are combinational from `reg_addr`. When byte lane 3 is enabled, a write loads the routing code from bits 26:24. When byte lane 0 is enabled, a write loads bridge enable from bit 0. A write without the matching byte-lane enable, or a write to any other offset, leaves that field unchanged. A read returns the code in bits 26:24, the enable in bit 0, the sticky flag in bit 31 and zeros in all other bits. A read of any other offset returns 0.
- R3: Code 0 with the bridge enabled routes port 0 to adapter 0 and port 2 to adapter 1. Port 1 goes to pad lane 1, and port 3 and pad lane 0 stay idle.
- R4: Code 1 with the bridge enabled routes port 0 to adapter 0 and port 2 to adapter 1. Port 3 goes to pad lane 1, and port 1 and pad lane 0 stay idle.
- R5: Code 2 with the bridge enabled routes port 2 to adapter 1 and port 3 to adapter 0. Port 0 goes to pad lane 0 and port 1 goes to pad lane 1.
- R6: Code 3 routes port 0 to adapter 0, port 3 to adapter 1 and also to pad lane 1, and port 2 to pad lane 0. Port 3's response comes from adapter 1 when the bridge is enabled and from pad lane 1 when it is disabled.
- R7: `bridged[c]` is high only when bridge enable is 1 and the code is valid, except that controller 0 is low under code 2 and controller 1 is low under code 3.
- R8: With bridge enable at 0, both adapter request outputs are zero and no adapter response reaches any port. Pad routes stay as the code selects.
- R9: A reserved code (4 to 7) makes every request and response output zero and both `bridged` bits low. It also sets the sticky flag (bit 31) in the same write, and the flag stays set after a valid code is written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register offset for write and read |
| reg_wr_data | input | 32 | Write data |
| reg_wr_be | input | 4 | Byte-lane write enables |
| reg_rd_data | output | 32 | Read data for `reg_addr` |
| ctl_req | input | 4*REQ_W | Request bundles of ports 0..3 |
| ctl_rsp | output | 4*RSP_W | Response bundles to ports 0..3 |
| ad_req | output | 2*REQ_W | Request bundles to adapters 0..1 |
| ad_rsp | input | 2*RSP_W | Response bundles from adapters 0..1 |
| pad_req | output | 2*REQ_W | Request bundles to pad lanes 0 (master) and 1 (slave) |
| pad_rsp | input | 2*RSP_W | Response bundles from pad lanes 0..1 |
| bridged | output | 2 | Per-controller bridged indication |

## Verification
The hardest case to reach is the fan-out under code 3. There the same slave request must appear on an adapter and on a pad lane, and the response source must switch with bridge enable while the code stays fixed. The stimulus writes code 3 and then toggles only the enable byte lane. It drives different random values on both adapter and pad responses, so a wrong source shows up in the compared response. The sticky flag is reached by writing a reserved code and then a valid one. Reads are interleaved between writes.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

    localparam int REG_W      = 32;
    localparam int BE_W       = REG_W / 8;
    localparam int MODE_W     = 3;
    localparam int MODE_LSB   = 24;
    localparam int EN_BIT     = 0;
    localparam int STICKY_BIT = 31;
    localparam int MODE_LANE  = MODE_LSB / 8;
    localparam int EN_LANE    = EN_BIT / 8;
    localparam int NUM_PORT   = 4;
    localparam int NUM_AD     = 2;
    localparam int NUM_LANE   = 2;
    localparam int NUM_CTL    = 2;

    typedef enum logic [2:0] {
        SRC_NONE = 3'd0,
        SRC_C0M  = 3'd1,
        SRC_C0S  = 3'd2,
        SRC_C1M  = 3'd3,
        SRC_C1S  = 3'd4
    } req_src_e;

    typedef enum logic [2:0] {
        RET_NONE = 3'd0,
        RET_AD0  = 3'd1,
        RET_AD1  = 3'd2,
        RET_PADM = 3'd3,
        RET_PADS = 3'd4
    } rsp_src_e;

    typedef struct packed {
        req_src_e [NUM_AD-1:0]   ad_src;
        req_src_e [NUM_LANE-1:0] pad_src;
        rsp_src_e [NUM_PORT-1:0] ret_src;
        logic     [NUM_CTL-1:0]  bridged;
    } route_plan_t;

    typedef struct packed {
        logic              sticky;
        logic [MODE_W-1:0] mode;
        logic              en;
    } ctrl_t;

    function automatic logic code_reserved(input logic [MODE_W-1:0] code);
        return code > MODE_W'(3);
    endfunction

    function automatic logic [REG_W-1:0] pack_ctrl(input ctrl_t c);
        logic [REG_W-1:0] v;
        v = '0;
        v[STICKY_BIT] = c.sticky;
        v[MODE_LSB +: MODE_W] = c.mode;
        v[EN_BIT] = c.en;
        return v;
    endfunction

endpackage

// File: rtl/xbar_ctrl_reg.sv
module xbar_ctrl_reg
    import xbar_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int CTRL_OFFSET = 'h30
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [REG_W-1:0]       wr_data,
    input  logic [BE_W-1:0]        wr_be,
    output ctrl_t                  ctrl,
    output logic [REG_W-1:0]       rd_data
);

    localparam logic [ADDR_W-1:0] OFF = ADDR_W'(CTRL_OFFSET);

    ctrl_t ctrl_q;
    logic  hit;
    logic  [MODE_W-1:0] new_code;

    assign hit      = (addr == OFF);
    assign new_code = wr_data[MODE_LSB +: MODE_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_en && hit) begin
            if (wr_be[MODE_LANE]) begin
                ctrl_q.mode <= new_code;
                if (code_reserved(new_code)) begin
                    ctrl_q.sticky <= 1'b1;
                end
            end
            if (wr_be[EN_LANE]) begin
                ctrl_q.en <= wr_data[EN_BIT];
            end
        end
    end

    assign ctrl    = ctrl_q;
    assign rd_data = hit ? pack_ctrl(ctrl_q) : '0;

    // R1: reset clears every field
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (ctrl_q.mode == '0 && !ctrl_q.en && !ctrl_q.sticky));

    // R2: code untouched when its byte lane is not enabled
    assert_mode_lane_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && hit && !wr_be[MODE_LANE]) |=> $stable(ctrl_q.mode));

    // R2: writes elsewhere leave the register alone
    assert_other_addr_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !hit) |=> $stable(ctrl_q));

    // R9: sticky flag never clears outside reset
    assert_sticky_hold_R9: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.sticky |=> ctrl_q.sticky);

endmodule

// File: rtl/xbar_route_decode.sv
module xbar_route_decode
    import xbar_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic              en,
    output route_plan_t       plan
);

    route_plan_t base;

    always_comb begin
        for (int k = 0; k < NUM_AD; k++)   base.ad_src[k]  = SRC_NONE;
        for (int l = 0; l < NUM_LANE; l++) base.pad_src[l] = SRC_NONE;
        for (int p = 0; p < NUM_PORT; p++) base.ret_src[p] = RET_NONE;
        base.bridged = '0;
        case (mode)
            3'd0: begin
                base.ad_src[0]  = SRC_C0M;
                base.ad_src[1]  = SRC_C1M;
                base.pad_src[1] = SRC_C0S;
                base.ret_src[0] = RET_AD0;
                base.ret_src[2] = RET_AD1;
                base.ret_src[1] = RET_PADS;
                base.bridged    = 2'b11;
            end
            3'd1: begin
                base.ad_src[0]  = SRC_C0M;
                base.ad_src[1]  = SRC_C1M;
                base.pad_src[1] = SRC_C1S;
                base.ret_src[0] = RET_AD0;
                base.ret_src[2] = RET_AD1;
                base.ret_src[3] = RET_PADS;
                base.bridged    = 2'b11;
            end
            3'd2: begin
                base.ad_src[1]  = SRC_C1M;
                base.ad_src[0]  = SRC_C1S;
                base.pad_src[0] = SRC_C0M;
                base.pad_src[1] = SRC_C0S;
                base.ret_src[2] = RET_AD1;
                base.ret_src[3] = RET_AD0;
                base.ret_src[0] = RET_PADM;
                base.ret_src[1] = RET_PADS;
                base.bridged    = 2'b10;
            end
            3'd3: begin
                base.ad_src[0]  = SRC_C0M;
                base.ad_src[1]  = SRC_C1S;
                base.pad_src[0] = SRC_C1M;
                base.pad_src[1] = SRC_C1S;
                base.ret_src[0] = RET_AD0;
                base.ret_src[3] = RET_AD1;
                base.ret_src[2] = RET_PADM;
                base.bridged    = 2'b01;
            end
            default: ;
        endcase
    end

    always_comb begin
        plan = base;
        if (!en) begin
            for (int k = 0; k < NUM_AD; k++) plan.ad_src[k] = SRC_NONE;
            for (int p = 0; p < NUM_PORT; p++) begin
                if (base.ret_src[p] == RET_AD0 || base.ret_src[p] == RET_AD1) begin
                    plan.ret_src[p] = RET_NONE;
                end
            end
            // fan-out port falls back to its pad lane
            if (mode == 3'd3) plan.ret_src[3] = RET_PADS;
            plan.bridged = '0;
        end
    end

endmodule

// File: rtl/xbar_route_mux.sv
module xbar_route_mux
    import xbar_pkg::*;
#(
    parameter int REQ_W = 16,
    parameter int RSP_W = 16
) (
    input  route_plan_t                       plan,
    input  logic [NUM_PORT-1:0][REQ_W-1:0]    ctl_req,
    input  logic [NUM_AD-1:0][RSP_W-1:0]      ad_rsp,
    input  logic [NUM_LANE-1:0][RSP_W-1:0]    pad_rsp,
    output logic [NUM_PORT-1:0][RSP_W-1:0]    ctl_rsp,
    output logic [NUM_AD-1:0][REQ_W-1:0]      ad_req,
    output logic [NUM_LANE-1:0][REQ_W-1:0]    pad_req
);

    function automatic logic [REQ_W-1:0] pick_req(
        input req_src_e s, input logic [NUM_PORT-1:0][REQ_W-1:0] r);
        case (s)
            SRC_C0M: return r[0];
            SRC_C0S: return r[1];
            SRC_C1M: return r[2];
            SRC_C1S: return r[3];
            default: return '0;
        endcase
    endfunction

    function automatic logic [RSP_W-1:0] pick_rsp(
        input rsp_src_e s,
        input logic [NUM_AD-1:0][RSP_W-1:0] a,
        input logic [NUM_LANE-1:0][RSP_W-1:0] d);
        case (s)
            RET_AD0:  return a[0];
            RET_AD1:  return a[1];
            RET_PADM: return d[0];
            RET_PADS: return d[1];
            default:  return '0;
        endcase
    endfunction

    for (genvar k = 0; k < NUM_AD; k++) begin : g_ad
        assign ad_req[k] = pick_req(plan.ad_src[k], ctl_req);
    end

    for (genvar l = 0; l < NUM_LANE; l++) begin : g_pad
        assign pad_req[l] = pick_req(plan.pad_src[l], ctl_req);
    end

    for (genvar p = 0; p < NUM_PORT; p++) begin : g_ret
        assign ctl_rsp[p] = pick_rsp(plan.ret_src[p], ad_rsp, pad_rsp);
    end

endmodule

// File: rtl/ata_sata_xbar.sv
module ata_sata_xbar
    import xbar_pkg::*;
#(
    parameter int REQ_W       = 16,
    parameter int RSP_W       = 16,
    parameter int ADDR_W      = 8,
    parameter int CTRL_OFFSET = 'h30
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  reg_wr_en,
    input  logic [ADDR_W-1:0]                     reg_addr,
    input  logic [31:0]                           reg_wr_data,
    input  logic [3:0]                            reg_wr_be,
    output logic [31:0]                           reg_rd_data,
    input  logic [3:0][REQ_W-1:0]                 ctl_req,
    output logic [3:0][RSP_W-1:0]                 ctl_rsp,
    output logic [1:0][REQ_W-1:0]                 ad_req,
    input  logic [1:0][RSP_W-1:0]                 ad_rsp,
    output logic [1:0][REQ_W-1:0]                 pad_req,
    input  logic [1:0][RSP_W-1:0]                 pad_rsp,
    output logic [1:0]                            bridged
);

    ctrl_t       ctrl;
    route_plan_t plan;

    xbar_ctrl_reg #(
        .ADDR_W      (ADDR_W),
        .CTRL_OFFSET (CTRL_OFFSET)
    ) u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr_en),
        .addr    (reg_addr),
        .wr_data (reg_wr_data),
        .wr_be   (reg_wr_be),
        .ctrl    (ctrl),
        .rd_data (reg_rd_data)
    );

    xbar_route_decode u_dec (
        .mode (ctrl.mode),
        .en   (ctrl.en),
        .plan (plan)
    );

    xbar_route_mux #(
        .REQ_W (REQ_W),
        .RSP_W (RSP_W)
    ) u_mux (
        .plan    (plan),
        .ctl_req (ctl_req),
        .ad_rsp  (ad_rsp),
        .pad_rsp (pad_rsp),
        .ctl_rsp (ctl_rsp),
        .ad_req  (ad_req),
        .pad_req (pad_req)
    );

    assign bridged = plan.bridged;

    // R7: controller 0 never bridged under code 2, controller 1 never under code 3
    assert_unbridged_R7: assert property (@(posedge clk) disable iff (rst)
        ((ctrl.mode == 3'd2) |-> !bridged[0]) and ((ctrl.mode == 3'd3) |-> !bridged[1]));

    // R8: adapters see no traffic while the bridge is off
    assert_bridge_off_R8: assert property (@(posedge clk) disable iff (rst)
        !ctrl.en |-> (ad_req == '0 && bridged == 2'b00));

    // R9: reserved code idles every output
    assert_reserved_idle_R9: assert property (@(posedge clk) disable iff (rst)
        code_reserved(ctrl.mode) |->
            (ad_req == '0 && pad_req == '0 && ctl_rsp == '0 && bridged == 2'b00 && ctrl.sticky));

    // R6: fan-out port reaches adapter 1 and pad lane 1 together
    assert_fanout_R6: assert property (@(posedge clk) disable iff (rst)
        (ctrl.mode == 3'd3 && ctrl.en) |-> (ad_req[1] == ctl_req[3] && pad_req[1] == ctl_req[3]));

endmodule

// File: tb/tb_ata_sata_xbar.sv
`timescale 1ns/1ps
module tb_ata_sata_xbar;

    localparam int REQ_W = 16;
    localparam int RSP_W = 16;
    localparam int ADDR_W = 8;
    localparam realtime HALF = 2.5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reg_wr_en = 1'b0;
    logic [ADDR_W-1:0] reg_addr = 8'h30;
    logic [31:0] reg_wr_data = '0;
    logic [3:0] reg_wr_be = '0;
    logic [31:0] reg_rd_data;
    logic [3:0][REQ_W-1:0] ctl_req = '0;
    logic [3:0][RSP_W-1:0] ctl_rsp;
    logic [1:0][REQ_W-1:0] ad_req;
    logic [1:0][RSP_W-1:0] ad_rsp = '0;
    logic [1:0][REQ_W-1:0] pad_req;
    logic [1:0][RSP_W-1:0] pad_rsp = '0;
    logic [1:0] bridged;

    int checks = 0;
    int errors = 0;
    bit live = 0;
    bit done = 0;

    // model state
    int m_mode = 0;
    bit m_en = 0;
    bit m_sticky = 0;

    always #HALF clk = ~clk;

    ata_sata_xbar #(.REQ_W(REQ_W), .RSP_W(RSP_W), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wr_data(reg_wr_data), .reg_wr_be(reg_wr_be), .reg_rd_data(reg_rd_data),
        .ctl_req(ctl_req), .ctl_rsp(ctl_rsp), .ad_req(ad_req), .ad_rsp(ad_rsp),
        .pad_req(pad_req), .pad_rsp(pad_rsp), .bridged(bridged)
    );

    // behavioural register model
    always @(posedge clk) begin
        if (rst) begin
            m_mode = 0; m_en = 0; m_sticky = 0;
        end else if (reg_wr_en && reg_addr == 8'h30) begin
            if (reg_wr_be[3]) begin
                m_mode = int'(reg_wr_data[26:24]);
                if (m_mode > 3) m_sticky = 1;
            end
            if (reg_wr_be[0]) m_en = reg_wr_data[0];
        end
    end

    // port-centric destination tables
    function automatic int adapter_of(int mode, int p);
        case (mode)
            0, 1: return (p == 0) ? 0 : (p == 2) ? 1 : -1;
            2:    return (p == 2) ? 1 : (p == 3) ? 0 : -1;
            3:    return (p == 0) ? 0 : (p == 3) ? 1 : -1;
            default: return -1;
        endcase
    endfunction

    function automatic int lane_of(int mode, int p);
        case (mode)
            0: return (p == 1) ? 1 : -1;
            1: return (p == 3) ? 1 : -1;
            2: return (p == 0) ? 0 : (p == 1) ? 1 : -1;
            3: return (p == 2) ? 0 : (p == 3) ? 1 : -1;
            default: return -1;
        endcase
    endfunction

    function automatic string route_tag(int mode, bit en);
        if (mode > 3) return "R9";
        if (!en) return "R8";
        case (mode)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (live) begin
            logic [1:0][REQ_W-1:0] e_ad;
            logic [1:0][REQ_W-1:0] e_pad;
            logic [3:0][RSP_W-1:0] e_rsp;
            logic [1:0] e_br;
            logic [31:0] e_rd;
            string tg;
            e_ad = '0; e_pad = '0; e_rsp = '0;
            tg = route_tag(m_mode, m_en);
            for (int p = 0; p < 4; p++) begin
                int a;
                int l;
                a = adapter_of(m_mode, p);
                l = lane_of(m_mode, p);
                if (a >= 0 && m_en) e_ad[a] = ctl_req[p];
                if (l >= 0) e_pad[l] = ctl_req[p];
                if (a >= 0 && m_en) e_rsp[p] = ad_rsp[a];
                else if (l >= 0) e_rsp[p] = pad_rsp[l];
            end
            for (int c = 0; c < 2; c++) begin
                e_br[c] = m_en && m_mode <= 3 && !(m_mode == 2 && c == 0) && !(m_mode == 3 && c == 1);
            end
            e_rd = '0;
            if (reg_addr == 8'h30) begin
                e_rd[31] = m_sticky;
                e_rd[26:24] = 3'(m_mode);
                e_rd[0] = m_en;
            end
            check(ad_req == e_ad, tg, "adapter requests", 64'(ad_req), 64'(e_ad));
            check(pad_req == e_pad, tg, "pad requests", 64'(pad_req), 64'(e_pad));
            check(ctl_rsp == e_rsp, tg, "port responses", 64'(ctl_rsp), 64'(e_rsp));
            check(bridged == e_br, "R7", "bridged", 64'(bridged), 64'(e_br));
            check(reg_rd_data == e_rd, "R2", "readback", 64'(reg_rd_data), 64'(e_rd));
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
        @(posedge clk); #1;
        reg_wr_en = 1'b1; reg_addr = a; reg_wr_data = d; reg_wr_be = be;
        @(posedge clk); #1;
        reg_wr_en = 1'b0; reg_addr = 8'h30;
    endtask

    task automatic traffic(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            ctl_req = {$urandom, $urandom};
            ad_rsp  = $urandom;
            pad_rsp = $urandom;
            reg_addr = (i % 5 == 4) ? 8'h34 : 8'h30;
        end
        @(posedge clk); #1;
        reg_addr = 8'h30;
    endtask

    function automatic logic [31:0] cfg(input int code, input bit en);
        logic [31:0] v;
        v = 32'hF8FF_FFFE;
        v[26:24] = 3'(code);
        v[0] = en;
        return v;
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(reg_rd_data == 32'h0, "R1", "reset readback", 64'(reg_rd_data), 64'h0);
        check(bridged == 2'b00, "R1", "reset bridged", 64'(bridged), 64'h0);
        live = 1;
        traffic(10);
        // R3..R6 with bridge on and off
        for (int en = 1; en >= 0; en--) begin
            for (int m = 0; m < 4; m++) begin
                wr(8'h30, cfg(m, en[0]), 4'hF);
                traffic(25);
            end
        end
        // R6: code 3, toggle only the enable lane
        wr(8'h30, cfg(3, 1'b1), 4'hF);
        traffic(10);
        wr(8'h30, 32'h0000_0000, 4'h1);
        traffic(10);
        wr(8'h30, 32'h0000_0001, 4'h1);
        traffic(10);
        // R2: masked and misaddressed writes
        wr(8'h30, cfg(1, 1'b0), 4'h7);
        traffic(8);
        wr(8'h30, cfg(2, 1'b1), 4'h8);
        traffic(8);
        wr(8'h2C, cfg(0, 1'b0), 4'hF);
        traffic(8);
        // R9: reserved codes and sticky flag
        for (int r = 4; r < 8; r++) begin
            wr(8'h30, cfg(r, 1'b1), 4'hF);
            traffic(8);
        end
        wr(8'h30, cfg(0, 1'b1), 4'hF);
        @(negedge clk);
        check(reg_rd_data[31] == 1'b1, "R9", "sticky after valid code", 64'(reg_rd_data[31]), 64'h1);
        traffic(10);
        live = 0;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule